// File: doc/BRIEF.md
# Unpacked BCD Adjust Unit

This unit performs the decimal correction that follows a byte addition or subtraction on unpacked BCD digits held in a 16-bit accumulator pair: the low byte holds one digit and the high byte holds the next digit up. A request carries the 16-bit accumulator, the incoming half-carry flag and an operation select. One cycle after the request is accepted, the unit presents the corrected accumulator together with the half-carry and carry flags.

The result matches real processor behaviour for every 16-bit input, including inputs that are not valid unpacked BCD. The plus-or-minus-6 correction is applied to the whole 16-bit value, not to the low byte alone. Any carry or borrow out of the low byte therefore reaches the high byte, and it comes on top of the explicit high-byte step of one. With a low byte of 0xFF and a high byte of 0x00, an addition adjust returns 0x0205.

Requests enter through a valid/ready interface and results leave through another. An accepted request sits in a single output register. While a result waits because `out_ready` is low, `in_ready` stays low, no new request is taken, and the waiting result keeps all of its values.

Top module: `bcd_adj_unit`

## Requirements
- R1: Correction runs when the incoming half-carry flag is 1, or when bits [3:0] of the low byte are 10 or more. A low nibble of 9 or less with the flag at 0 gives no correction.
- R2: For an addition adjust with correction, 6 is added to the full 16-bit value first, so a carry out of bit 7 enters the high byte. The high byte (bits [15:8]) is then incremented by 1, modulo 256.
- R3: An addition adjust of 0x00FF with the flag at 0 returns 0x0205, with both flags set.
- R4: For a subtraction adjust with correction, 6 is subtracted from the full 16-bit value first, borrowing from the high byte. The high byte is then decremented by 1, modulo 256.
- R5: When correction runs, `out_af` and `out_cf` are both 1. When it does not run, both are 0.
- R6: Bits [7:4] of `out_ax` are always 0 in a result.
- R7: Without correction, `out_ax` bits [15:8] and [3:0] equal the input's bits [15:8] and [3:0].
- R8: The select `in_op` = 0 chooses the addition adjust and `in_op` = 1 chooses the subtraction adjust.
- R9: After reset `out_valid` is 0 and `in_ready` is 1. A request accepted on a clock edge (`in_valid` and `in_ready` both 1) appears with `out_valid` = 1 after that edge.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_ax`, `out_af` and `out_cf` hold their values. A request offered during that time is not taken.
- R11: Carry or borrow out of bit 15 is discarded. An addition adjust of 0xFFFF gives 0x0105, and a subtraction adjust of 0x0000 with the flag at 1 gives 0xFE0A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_ax | input | 16 | Accumulator value to adjust |
| in_af | input | 1 | Incoming half-carry flag |
| in_op | input | 1 | 0 = addition adjust, 1 = subtraction adjust |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_ax | output | 16 | Adjusted accumulator |
| out_af | output | 1 | Outgoing half-carry flag |
| out_cf | output | 1 | Outgoing carry flag |

## Verification
The bench sweeps every low-byte value, with both flag values and both operations, against a set of high bytes: 0x00, 0x01, 0x7F, 0x80, 0xFE and 0xFF. The low-byte sweep separates the nibble threshold (9 against 10) from the flag-forced correction. The high bytes at the wrap points show whether the carry or borrow out of the low byte actually reaches the high byte, and whether anything above bit 15 is dropped. Directed cases pin down the 0x00FF and 0xFFFF addition results and the 0x0000 subtraction result. A stall case holds `out_ready` low and offers a second request, to confirm the waiting result holds and the second request is not taken.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned DIGIT_W  = 4;
  localparam int unsigned DIGIT_MAX = 9;
  localparam int unsigned STEP     = 6;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } adj_op_e;
endpackage

// File: rtl/bcd_adj_detect.sv
module bcd_adj_detect #(
  parameter int unsigned DIGIT_W   = 4,
  parameter int unsigned DIGIT_MAX = 9
) (
  input  logic [DIGIT_W-1:0] digit,
  input  logic               half_carry,
  output logic               need_fix
);
  localparam logic [DIGIT_W-1:0] LIMIT = DIGIT_W'(DIGIT_MAX);

  always_comb begin
    need_fix = half_carry || (digit > LIMIT);
  end
endmodule

// File: rtl/bcd_adj_core.sv
module bcd_adj_core
  import bcd_adj_pkg::*;
#(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned DIGIT_W = 4,
  parameter int unsigned STEP    = 6
) (
  input  logic [WORD_W-1:0] ax_in,
  input  adj_op_e           op,
  input  logic              need_fix,
  output logic [WORD_W-1:0] ax_out
);
  localparam int unsigned HIGH_W = WORD_W - LANE_W;
  localparam int unsigned PAD_W  = LANE_W - DIGIT_W;
  localparam logic [WORD_W-1:0] STEP_W = WORD_W'(STEP);
  localparam logic [HIGH_W-1:0] ONE_H  = HIGH_W'(1);

  logic [WORD_W-1:0] stepped;
  logic [HIGH_W-1:0] high_next;
  logic [WORD_W-1:0] chosen;

  // whole-word correction: carry/borrow leaves the low lane into the high lane
  always_comb begin
    if (op == OP_ADD) stepped = ax_in + STEP_W;
    else              stepped = ax_in - STEP_W;
  end

  // explicit high-lane step, stacked on top of any carry or borrow
  always_comb begin
    if (op == OP_ADD) high_next = stepped[WORD_W-1:LANE_W] + ONE_H;
    else              high_next = stepped[WORD_W-1:LANE_W] - ONE_H;
  end

  always_comb begin
    if (need_fix) chosen = {high_next, stepped[LANE_W-1:0]};
    else          chosen = ax_in;
  end

  // only the low digit of the low lane survives
  generate
    if (PAD_W > 0) begin : g_pad
      assign ax_out = {chosen[WORD_W-1:LANE_W], {PAD_W{1'b0}}, chosen[DIGIT_W-1:0]};
    end else begin : g_nopad
      assign ax_out = chosen;
    end
  endgenerate

  always_comb begin
    if (!need_fix)
      assert_keep_high_R7: assert (ax_out[WORD_W-1:LANE_W] == ax_in[WORD_W-1:LANE_W]);
    else
      assert_high_moves_R2_R4: assert (ax_out[WORD_W-1:LANE_W] != ax_in[WORD_W-1:LANE_W]);
  end
endmodule

// File: rtl/bcd_adj_stage.sv
module bcd_adj_stage #(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/bcd_adj_unit.sv
module bcd_adj_unit
  import bcd_adj_pkg::*;
#(
  parameter int unsigned AX_W    = bcd_adj_pkg::WORD_W,
  parameter int unsigned LN_W    = bcd_adj_pkg::LANE_W,
  parameter int unsigned DG_W    = bcd_adj_pkg::DIGIT_W,
  parameter int unsigned DG_MAX  = bcd_adj_pkg::DIGIT_MAX,
  parameter int unsigned FIX     = bcd_adj_pkg::STEP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [AX_W-1:0] in_ax,
  input  logic            in_af,
  input  logic            in_op,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [AX_W-1:0] out_ax,
  output logic            out_af,
  output logic            out_cf
);
  localparam int unsigned PAY_W = AX_W + 2;

  logic            need_fix;
  logic [AX_W-1:0] ax_fixed;
  adj_op_e         op_sel;
  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;

  assign op_sel = adj_op_e'(in_op);

  bcd_adj_detect #(.DIGIT_W(DG_W), .DIGIT_MAX(DG_MAX)) u_detect (
    .digit      (in_ax[DG_W-1:0]),
    .half_carry (in_af),
    .need_fix   (need_fix)
  );

  bcd_adj_core #(.WORD_W(AX_W), .LANE_W(LN_W), .DIGIT_W(DG_W), .STEP(FIX)) u_core (
    .ax_in    (in_ax),
    .op       (op_sel),
    .need_fix (need_fix),
    .ax_out   (ax_fixed)
  );

  assign pay_in = {need_fix, need_fix, ax_fixed};

  bcd_adj_stage #(.DATA_W(PAY_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign out_ax = pay_out[AX_W-1:0];
  assign out_cf = pay_out[AX_W];
  assign out_af = pay_out[AX_W+1];

  assert_flag_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_af) |=> (out_af && out_cf));
  assert_nib_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ax[LN_W-1:DG_W] == '0));
endmodule

// File: tb/bcd_adj_unit_tb.sv
module bcd_adj_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_ax = 16'h0;
  logic        in_af = 1'b0;
  logic        in_op = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_ax;
  logic        out_af;
  logic        out_cf;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  bcd_adj_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ax(in_ax), .in_af(in_af), .in_op(in_op), .out_valid(out_valid),
    .out_ready(out_ready), .out_ax(out_ax), .out_af(out_af), .out_cf(out_cf)
  );

  function automatic int model_ax(int ax, bit af, bit sub);
    int t;
    bit fix;
    fix = af || ((ax % 16) > 9);
    t = ax;
    if (fix) begin
      if (!sub) t = ((t + 6) % 65536 + 256) % 65536;
      else      t = ((t - 6 + 65536) % 65536 - 256 + 65536) % 65536;
    end
    return (t / 256) * 256 + (t % 16);
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic run(int ax, bit af, bit sub, string tag);
    int e;
    bit fix;
    @(negedge clk);
    in_valid = 1'b1; in_ax = ax[15:0]; in_af = af; in_op = sub; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    e = model_ax(ax, af, sub);
    fix = af || ((ax % 16) > 9);
    check({tag, " valid R9"}, int'(out_valid), 1);
    check(tag, int'(out_ax), e);
    check({tag, " flags R5"}, int'({out_af, out_cf}), fix ? 3 : 0);
  endtask

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int highs[6] = '{0, 1, 127, 128, 254, 255};
    repeat (3) @(negedge clk);
    check("reset out_valid R9", int'(out_valid), 0);
    check("reset in_ready R9", int'(in_ready), 1);
    rst_n = 1'b1;

    // directed corner cases
    run(16'h00FF, 1'b0, 1'b0, "carry into high byte R3");
    run(16'hFFFF, 1'b0, 1'b0, "wrap add R11");
    run(16'h0000, 1'b1, 1'b1, "wrap sub R11");
    run(16'h0309, 1'b0, 1'b0, "nibble 9 no fix R1");
    run(16'h030A, 1'b0, 1'b0, "nibble 10 fix R1");
    run(16'h0305, 1'b1, 1'b0, "flag forces fix R1");
    run(16'h0505, 1'b1, 1'b1, "sub select R8");
    run(16'h0505, 1'b1, 1'b0, "add select R8");
    run(16'h12F3, 1'b0, 1'b0, "upper nibble cleared R6");

    // sweep
    for (int h = 0; h < 6; h++)
      for (int l = 0; l < 256; l++)
        for (int a = 0; a < 2; a++)
          for (int s = 0; s < 2; s++) begin
            string tag;
            bit fix;
            fix = (a != 0) || ((l % 16) > 9);
            if (!fix)      tag = "pass-through R7";
            else if (s==0) tag = "add adjust R2";
            else           tag = "sub adjust R4";
            run(highs[h] * 256 + l, a[0], s[0], tag);
          end

    // back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_ax = 16'h00FF; in_af = 1'b0; in_op = 1'b0;
    @(negedge clk);
    in_ax = 16'h4444; in_af = 1'b0; in_op = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("stall in_ready R10", int'(in_ready), 0);
      check("stall hold ax R10", int'(out_ax), 16'h0205);
      check("stall hold flags R10", int'({out_af, out_cf}), 3);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check("stalled request dropped R10", int'(out_valid), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule